// File: doc/BRIEF.md
# Mersenne-Prime Modular Inverter

This block is a sequential unit that returns the multiplicative inverse of an operand modulo a Mersenne prime `P = 2^Q - 1`, where `Q` is a parameter (default 7, so `P = 127`). It needs no divider and no multiplier. Each round first strips the low zero bits of a working value `y`, counting them as `e`. It then scales an accumulator `a` by `2^(Q-e)`. Because the modulus is all ones, that scaling is a plain rotation of `Q` bits. If `y` is not yet 1, two value pairs advance together: `(a, b)` becomes `(a + b, a)` and `(y, z)` becomes `(y + z, y)`. The sum `a + b` is reduced with an end-around carry. Throughout, `a * x ≡ y` and `b * x ≡ z` (mod `P`), so when `y` reaches 1 the accumulator holds the inverse.

A caller pulses `start` with the operand on `x_in` while the unit is idle. The unit raises `busy` until it pulses `done`. With `done` it presents the inverse and a round count. The round count starts at 1 and grows by one for every pair update. An operand congruent to zero has no inverse. For such an operand the unit raises `err`, returns zero and does no rounds.

Top module: `mersenne_inverter`

## Requirements
- R1: While and after reset (active-low `rst_n`), `busy`, `done` and `err` are low, and `inv_out` and `iter_out` are zero, until the first accepted start.
- R2: A `start` seen at a rising edge while `busy` is low is accepted: the operand on `x_in` is captured and `busy` is high from that edge on. The all-ones code of `x_in` is treated as the value 0.
- R3: `done` is high for exactly one cycle per accepted start. `busy` falls at the same edge at which `done` rises.
- R4: For an operand `x` with `x mod P` not zero, `inv_out` lies in 1..P-1 and `(inv_out * x) mod P = 1`.
- R5: For an operand with `x mod P = 0` (input codes 0 and all-ones), `err` is high together with `done`, `inv_out` is 0 and `iter_out` is 1. For every other operand, `err` is low with `done`.
- R6: `iter_out` equals 1 plus the number of pair updates that the reduction performs before `y` reaches 1.
- R7: The number of rising edges from the accepting edge up to and including the edge that raises `done` equals the total count of stripped zero bits plus `iter_out`. For an error operand this number is 1.
- R8: A `start` pulse while `busy` is high is ignored: the running computation finishes with the result for the operand first captured.
- R9: `inv_out`, `iter_out` and `err` keep their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; accepted only while idle |
| x_in | input | Q | Operand to invert |
| busy | output | 1 | High while a computation runs |
| done | output | 1 | One-cycle pulse when the result is ready |
| err | output | 1 | Operand was congruent to zero |
| inv_out | output | Q | Inverse of the operand modulo 2^Q-1 |
| iter_out | output | ITER_W | Round count, starting at 1 |

## Verification
The bench builds the unit with `Q = 7` (`P = 127`). With that modulus every one of the 128 input codes can be swept. The sweep covers both encodings of zero, the operand 1 that ends in a single round, and powers of two that need long strip runs. For each code the bench computes its own inverse by search and replays the reduction arithmetically to get the round count and the strip count. From these it checks the latency cycle by cycle. One extra run fires a second start in the middle of a computation, to show that the second start is ignored.

// File: rtl/mi_pkg.sv
// Package: shared state type for the Mersenne modular inverter.
// Assumes nothing beyond a two-state control flow (idle / running).
package mi_pkg;
    typedef enum logic {
        MI_IDLE = 1'b0,
        MI_RUN  = 1'b1
    } mi_state_t;
endpackage

// File: rtl/mi_rotl.sv
// mi_rotl: left rotation of a W-bit word by AMT positions.
// Multiplying by 2^k modulo 2^W-1 equals rotating left by k.
// Assumes amt < W; larger values are not produced by the caller.
module mi_rotl #(
    parameter int W  = 7,
    parameter int SW = 3
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] dbl;

    // Rotate by shifting a doubled copy and keeping the upper half.
    always_comb begin
        dbl  = {din, din} << amt;
        dout = dbl[2*W-1:W];
    end
endmodule

// File: rtl/mi_addmod.sv
// mi_addmod: addition modulo 2^W-1 with an end-around carry.
// Assumes both inputs are canonical (never all ones); the output is
// canonical too, because an all-ones sum is folded to zero.
module mi_addmod #(
    parameter int W = 7
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W:0]   raw;
    logic [W-1:0] wrap;

    // Add, feed the carry back into bit 0, then fold all ones to zero.
    always_comb begin
        raw  = {1'b0, a} + {1'b0, b};
        wrap = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
        s    = (&wrap) ? '0 : wrap;
    end
endmodule

// File: rtl/mersenne_inverter.sv
// mersenne_inverter: inverse of x modulo P = 2^Q-1 by relational reduction.
// Uses only shifts, rotations and additions. One zero bit of y is
// stripped per clock; each scale-and-update round takes one clock.
// Assumes P is prime, so every nonzero residue has an inverse.
module mersenne_inverter
    import mi_pkg::*;
#(
    parameter int Q      = 7,
    parameter int ITER_W = Q + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [Q-1:0]      x_in,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [Q-1:0]      inv_out,
    output logic [ITER_W-1:0] iter_out
);
    localparam int          EW   = $clog2(Q + 1);
    localparam logic [Q-1:0] PMOD = {Q{1'b1}};

    mi_state_t   state;
    logic [Q-1:0] acc_a, acc_b;
    logic [Q:0]   wy, wz;
    logic [EW-1:0] ecnt;
    logic [ITER_W-1:0] rounds;

    logic [Q-1:0]  x_red;
    logic [EW-1:0] rot_amt;
    logic [Q-1:0]  a_rot;
    logic [Q-1:0]  a_sum;

    // Reduce the operand: the all-ones code is congruent to zero.
    always_comb x_red = (x_in == PMOD) ? '0 : x_in;

    // Rotation amount (Q - e) mod Q; e never exceeds Q.
    always_comb rot_amt = (ecnt == '0 || ecnt == EW'(Q)) ? '0 : EW'(Q) - ecnt;

    mi_rotl #(.W(Q), .SW(EW)) u_rot (
        .din  (acc_a),
        .amt  (rot_amt),
        .dout (a_rot)
    );

    mi_addmod #(.W(Q)) u_add (
        .a (a_rot),
        .b (acc_b),
        .s (a_sum)
    );

    // Busy while the reduction loop is running.
    always_comb busy = (state == MI_RUN);

    // Control and datapath: load, strip, scale-and-update, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MI_IDLE;
            acc_a    <= '0;
            acc_b    <= '0;
            wy       <= '0;
            wz       <= '0;
            ecnt     <= '0;
            rounds   <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            inv_out  <= '0;
            iter_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                MI_IDLE: begin
                    if (start) begin
                        acc_a  <= Q'(1);
                        acc_b  <= '0;
                        wy     <= {1'b0, x_red};
                        wz     <= {1'b0, PMOD};
                        ecnt   <= '0;
                        rounds <= ITER_W'(1);
                        state  <= MI_RUN;
                    end
                end
                MI_RUN: begin
                    if (wy == '0) begin
                        err      <= 1'b1;
                        inv_out  <= '0;
                        iter_out <= rounds;
                        done     <= 1'b1;
                        state    <= MI_IDLE;
                    end else if (!wy[0]) begin
                        wy   <= wy >> 1;
                        ecnt <= ecnt + EW'(1);
                    end else if (wy == (Q+1)'(1)) begin
                        err      <= 1'b0;
                        inv_out  <= a_rot;
                        iter_out <= rounds;
                        done     <= 1'b1;
                        state    <= MI_IDLE;
                    end else begin
                        acc_a  <= a_sum;
                        acc_b  <= a_rot;
                        wy     <= wy + wz;
                        wz     <= wy;
                        ecnt   <= '0;
                        rounds <= rounds + ITER_W'(1);
                    end
                end
                default: state <= MI_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mi_checker.sv
// mi_checker: port-level properties of mersenne_inverter, bound below.
// Keeps its own copy of the accepted operand to judge the result.
module mi_checker #(
    parameter int Q      = 7,
    parameter int ITER_W = Q + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [Q-1:0]      x_in,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [Q-1:0]      inv_out,
    input logic [ITER_W-1:0] iter_out
);
    localparam int PV = (1 << Q) - 1;

    logic [Q-1:0]   x_cap;
    logic [2*Q-1:0] prod;

    // Capture the reduced operand whenever a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            x_cap <= '0;
        else if (start && !busy)
            x_cap <= (x_in == {Q{1'b1}}) ? '0 : x_in;
    end

    // Product of result and operand for the inverse property.
    always_comb prod = inv_out * x_cap;

    p_busy_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_inverse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((32'(prod) % PV) == 1 && inv_out != '0));

    p_error_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (inv_out == '0 && iter_out == ITER_W'(1)));

    p_error_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (x_cap == '0)));

    p_count_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iter_out != '0));

    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(inv_out) && $stable(iter_out) && $stable(err)));
endmodule

bind mersenne_inverter mi_checker #(.Q(Q), .ITER_W(ITER_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .x_in     (x_in),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .inv_out  (inv_out),
    .iter_out (iter_out)
);

// File: tb/sim_mersenne_inverter.sv
// sim_mersenne_inverter: exhaustive sweep of all operand codes at Q = 7.
module sim_mersenne_inverter;
    localparam int Q  = 7;
    localparam int IW = Q + 3;
    localparam int PV = (1 << Q) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [Q-1:0]  x_in = '0;
    logic          busy, done, err;
    logic [Q-1:0]  inv_out;
    logic [IW-1:0] iter_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mersenne_inverter #(.Q(Q), .ITER_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .busy(busy), .done(done), .err(err),
        .inv_out(inv_out), .iter_out(iter_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Arithmetic model of the reduction: round count and stripped bits.
    task automatic model(input int xv, output int exp_inv, output int rounds, output int strips);
        int y, z, t, xr;
        xr = (xv == PV) ? 0 : xv;
        exp_inv = 0;
        for (int i = 1; i < PV; i++)
            if ((i * xr) % PV == 1) exp_inv = i;
        rounds = 1; strips = 0;
        if (xr == 0) return;
        y = xr; z = PV;
        forever begin
            while (y % 2 == 0) begin y = y / 2; strips++; end
            if (y == 1) break;
            t = y; y = y + z; z = t; rounds++;
        end
    endtask

    task automatic run_one(input int xv, input bit mid_start);
        int cyc, e_inv, e_rounds, e_strips, xr;
        model(xv, e_inv, e_rounds, e_strips);
        xr = (xv == PV) ? 0 : xv;
        @(negedge clk);
        x_in = Q'(xv); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", busy, 1);
        cyc = 0;
        do begin
            if (mid_start && cyc == 1) begin
                x_in = Q'(5); start = 1'b1;
            end
            @(posedge clk); #1;
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 2000);
        if (mid_start)
            check(int'(inv_out) == e_inv, "R8 second start ignored", int'(inv_out), e_inv);
        check(busy == 1'b0, "R3 busy low with done", busy, 0);
        check(err == (xr == 0), "R5 error flag", err, (xr == 0));
        if (xr == 0) begin
            check(inv_out == '0, "R5 zero result", int'(inv_out), 0);
            check(cyc == 1, "R7 error latency", cyc, 1);
        end else begin
            check(int'(inv_out) == e_inv, "R4 inverse", int'(inv_out), e_inv);
            check(cyc == e_strips + e_rounds, "R7 latency", cyc, e_strips + e_rounds);
        end
        check(int'(iter_out) == e_rounds, "R6 round count", int'(iter_out), e_rounds);
        @(posedge clk); #1;
        check(done == 1'b0, "R3 single-cycle done", done, 0);
        check(int'(inv_out) == ((xr == 0) ? 0 : e_inv), "R9 result held", int'(inv_out), e_inv);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(busy == 0 && done == 0 && err == 0, "R1 reset flags", {busy, done, err}, 0);
        check(inv_out == '0 && iter_out == '0, "R1 reset data", int'(inv_out), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(busy == 0 && inv_out == '0, "R1 idle after reset", busy, 0);
        for (int xv = 0; xv <= PV; xv++) run_one(xv, 1'b0);
        run_one(3, 1'b1);
        run_one(64, 1'b1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule